// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM with Late Write

This block models a single-clock synchronous SRAM whose data bus never needs an idle cycle when traffic switches between reads and writes. Every cycle registers a command: address, read/write, byte-lane enables and three chip-select inputs. The data that belongs to that command moves two active clock edges later. A read returns its word on the output port in that slot. A write takes its word from the input port in that slot. Reads and writes therefore share one fixed two-cycle data slot, and any mix of them can be issued on consecutive cycles.

Because a write reaches the array two edges after its address, the write addresses wait in a two-stage pipeline. A read that follows a still-pending write to the same word gets the pending bytes merged over the stored word. A load/advance input either starts a new command or continues the previous one as a four-beat burst with linear or interleaved ordering. An active-low clock enable freezes the whole block. The word is 36 bits wide, arranged as four 9-bit lanes (8 data bits plus 1 parity bit each). The array depth is a parameter.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted and after it is released, rdValid is 0 and rdData is all zeros until the first read slot.
- R2: A read captured on active edge n drives rdData with the addressed word and sets rdValid to 1 just after active edge n+2. In every slot that does not carry a read, rdValid is 0.
- R3: For a write captured on active edge n, wrData is sampled on active edge n+2 and stored at the captured address.
- R4: byteEnN is sampled with the address. Bit i low enables lane i, which is bits 9i+8 down to 9i. Disabled lanes keep their old contents, and this holds for bursts too.
- R5: The block is selected only when selN=0, selHi=1 and selN2=0. A load edge with any other combination is a deselect: it writes nothing and gives rdValid=0 in its slot.
- R6: On an edge where clkEnN is 1, no state changes: rdData and rdValid hold, no command is captured, wrData is ignored, and the pending slots do not advance.
- R7: Reads and writes can be issued on every consecutive active edge in any order. A read that follows a write to the same address returns the written lanes, even when the write is still pending.
- R8: With ldN=1 the previous command type continues as a burst. Address bits above bit 1 stay at the base value. Bits 1:0 of beat k (k=1,2,3, then wrapping to 0) are base+k modulo 4 when burstIlv=0, and base XOR k when burstIlv=1.
- R9: wrN, selN, selHi, selN2 and addr are ignored on a continue edge (ldN=1). A continue after a deselect, or after reset before any load, is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| clkEnN | input | 1 | Active-low clock enable; 1 suspends the block |
| selN | input | 1 | Active-low chip select |
| selHi | input | 1 | Active-high chip select |
| selN2 | input | 1 | Second active-low chip select |
| ldN | input | 1 | 0 loads a new command, 1 continues a burst |
| wrN | input | 1 | 1 read, 0 write (sampled on load edges) |
| byteEnN | input | LANES | Active-low lane write enables |
| addr | input | ADDR_W | Word address |
| burstIlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wrData | input | LANES*LANE_W | Write data, due two active edges after its address |
| rdData | output | LANES*LANE_W | Registered read data |
| rdValid | output | 1 | Marks rdData as the result of a read in this slot |

## Verification
Every command resolves exactly two active edges after the edge that captured it. The bench keeps a two-entry queue of issued commands and drives the queued write word just before the edge where it is due. Right after that same edge it checks rdValid and rdData against a reference word array, which is updated only when a write becomes due. Suspended edges do not advance the queue. On those edges the bench checks instead that both outputs equal their values from before the edge.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKindT;

  // strobes handed from control to datapath for the current edge
  typedef struct packed {
    logic advance;   // clock enabled this edge
    logic rdLaunch;  // stage 1 holds a read: sample the array
    logic fwdHit;    // stage 2 write targets the stage 1 read address
    logic wrCommit;  // stage 2 holds a write: commit wrData
    logic outLoad;   // stage 2 holds a read: load the output register
  } strobeT;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic ilv);
    return ilv ? (base ^ step) : (base + step);
  endfunction

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selN2,
  input  logic              ldN,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstIlv,
  output strobeT            st,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrMask
);

  localparam int unsigned HI_W = ADDR_W - 2;

  opKindT            curKind;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beatCnt;

  opKindT            s1Kind, s2Kind;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0]  s1Mask, s2Mask;

  logic              selected;
  opKindT            newKind;
  logic [ADDR_W-1:0] newAddr;
  logic [1:0]        newCnt;

  always_comb begin
    selected = !selN && selHi && !selN2;
    if (!ldN) begin
      newKind = selected ? (wrN ? OP_READ : OP_WRITE) : OP_IDLE;
      newAddr = addr;
      newCnt  = 2'd0;
    end else begin
      newKind = curKind;
      newCnt  = beatCnt + 2'd1;
      newAddr = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], newCnt, burstIlv)};
    end
  end

  // burst state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curKind  <= OP_IDLE;
      baseAddr <= '0;
      beatCnt  <= 2'd0;
    end else if (!clkEnN) begin
      curKind <= newKind;
      beatCnt <= newCnt;
      if (!ldN) baseAddr <= addr;
    end
  end

  // two-stage command / write-address pipeline
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Kind <= OP_IDLE;
      s2Kind <= OP_IDLE;
      s1Addr <= '0;
      s2Addr <= '0;
      s1Mask <= '0;
      s2Mask <= '0;
    end else if (!clkEnN) begin
      s1Kind <= newKind;
      s1Addr <= newAddr;
      s1Mask <= ~byteEnN;
      s2Kind <= s1Kind;
      s2Addr <= s1Addr;
      s2Mask <= s1Mask;
    end
  end

  always_comb begin
    st.advance  = !clkEnN;
    st.rdLaunch = (s1Kind == OP_READ);
    st.wrCommit = (s2Kind == OP_WRITE);
    st.outLoad  = (s2Kind == OP_READ);
    st.fwdHit   = (s1Kind == OP_READ) && (s2Kind == OP_WRITE) && (s1Addr == s2Addr);
    rdAddr      = s1Addr;
    wrAddr      = s2Addr;
    wrMask      = s2Mask;
  end

  // R5: a load with an inactive select combination enters as deselect
  p_desel_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !ldN && !(!selN && selHi && !selN2)) |=> (s1Kind == OP_IDLE));

  // R8: a continue beat keeps the upper address bits of the base
  p_burst_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && ldN) |=> (s1Addr[ADDR_W-1:2] == $past(baseAddr[ADDR_W-1:2])));

  // R6: suspended edge leaves the pipeline untouched
  p_suspend_pipe_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(s1Addr) && $stable(s2Addr) && $stable(s2Kind)));

  // R2: a read in stage 1 reaches stage 2 on the next active edge
  p_read_hop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && st.rdLaunch) |=> (s2Kind == OP_READ));

  initial begin
    a_addr_width: assert (HI_W >= 1);
  end

endmodule

// File: rtl/zbt_dpath.sv
`timescale 1ns/1ps
module zbt_dpath
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  st,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrMask,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] senseQ;
  logic [DATA_W-1:0] fwdDataQ;
  logic [LANES-1:0]  fwdMaskQ;
  logic [DATA_W-1:0] mergedWord;

  // lane-masked commit of the delayed write data
  always_ff @(posedge clk) begin
    if (st.advance && st.wrCommit) begin
      for (int i = 0; i < int'(LANES); i++) begin
        if (wrMask[i]) mem[wrAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  // array sample for stage 1 read plus capture of the write committing alongside
  always_ff @(posedge clk) begin
    if (st.advance && st.rdLaunch) senseQ <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdMaskQ <= '0;
      fwdDataQ <= '0;
    end else if (st.advance && st.rdLaunch) begin
      fwdMaskQ <= st.fwdHit ? wrMask : '0;
      fwdDataQ <= wrData;
    end
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign mergedWord[g*LANE_W +: LANE_W] =
      fwdMaskQ[g] ? fwdDataQ[g*LANE_W +: LANE_W] : senseQ[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (st.advance) begin
      rdValid <= st.outLoad;
      if (st.outLoad) rdData <= mergedWord;
    end
  end

  // R2: read in stage 2 yields a valid output after the edge
  p_valid_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && st.outLoad) |=> rdValid);

  // R5: slots without a read show no valid output
  p_no_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.outLoad) |=> !rdValid);

  // R6: suspended edge holds the output register
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    !st.advance |=> ($stable(rdValid) && $stable(rdData)));

  // R7: forwarding only pairs a stage 1 read with a committing write
  p_fwd_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.fwdHit |-> (st.rdLaunch && st.wrCommit));

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    selN,
  input  logic                    selHi,
  input  logic                    selN2,
  input  logic                    ldN,
  input  logic                    wrN,
  input  logic [LANES-1:0]        byteEnN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burstIlv,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  strobeT            st;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;
  logic [LANES-1:0]  wrMask;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selN(selN), .selHi(selHi), .selN2(selN2),
    .ldN(ldN), .wrN(wrN), .byteEnN(byteEnN), .addr(addr), .burstIlv(burstIlv),
    .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrMask(wrMask)
  );

  zbt_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrMask(wrMask), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, clkEnN, selN, selHi, selN2, ldN, wrN, burstIlv;
  logic [LN-1:0] byteEnN;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData, rdData;
  logic          rdValid;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selN(selN), .selHi(selHi), .selN2(selN2),
    .ldN(ldN), .wrN(wrN), .byteEnN(byteEnN), .addr(addr), .burstIlv(burstIlv),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  // sus, ldN, wrN, {selN,selHi,selN2}, byteEnN, burstIlv, addr, data
  typedef struct packed {
    logic          sus;
    logic          ld;
    logic          wr;
    logic [2:0]    en;
    logic [LN-1:0] be;
    logic          ilv;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } rowT;

  localparam int N = 32;
  localparam rowT TBL [N] = '{
    '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b0,6'd5 ,36'h1_1111_1111},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd5 ,36'h0},
    '{1'b0,1'b0,1'b0,3'b010,4'hA,1'b0,6'd5 ,36'hA_BCDE_F012},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd5 ,36'h0},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd6 ,36'h0},
    '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b0,6'd7 ,36'h7_7777_7777},
    '{1'b0,1'b0,1'b1,3'b110,4'h0,1'b0,6'd7 ,36'h0},
    '{1'b0,1'b0,1'b0,3'b000,4'h0,1'b0,6'd7 ,36'hD_DDDD_DDDD},
    '{1'b0,1'b0,1'b0,3'b011,4'h0,1'b0,6'd7 ,36'hD_DDDD_DDDD},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd7 ,36'h0},
    '{1'b1,1'b0,1'b0,3'b010,4'h0,1'b0,6'd7 ,36'hE_EEEE_EEEE},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd9 ,36'h0},
    '{1'b0,1'b1,1'b0,3'b110,4'h0,1'b0,6'd0 ,36'h0},
    '{1'b1,1'b1,1'b1,3'b010,4'h0,1'b0,6'd0 ,36'h0},
    '{1'b0,1'b1,1'b1,3'b010,4'h0,1'b0,6'd0 ,36'h0},
    '{1'b0,1'b1,1'b1,3'b010,4'h0,1'b0,6'd0 ,36'h0},
    '{1'b0,1'b1,1'b1,3'b010,4'h0,1'b0,6'd0 ,36'h0},
    '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b1,6'd13,36'h1_0101_0101},
    '{1'b0,1'b1,1'b1,3'b110,4'h0,1'b1,6'd0 ,36'h2_0202_0202},
    '{1'b0,1'b1,1'b0,3'b010,4'h6,1'b1,6'd0 ,36'h3_0303_0303},
    '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b1,6'd0 ,36'h4_0404_0404},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b1,6'd13,36'h0},
    '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b1,6'd0 ,36'h0},
    '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b1,6'd0 ,36'h0},
    '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b1,6'd0 ,36'h0},
    '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b0,6'd20,36'h5_1234_5678},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd21,36'h0},
    '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b0,6'd21,36'h6_8765_4321},
    '{1'b0,1'b0,1'b1,3'b010,4'h0,1'b0,6'd20,36'h0},
    '{1'b0,1'b0,1'b1,3'b110,4'h0,1'b0,6'd20,36'h0},
    '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b0,6'd3 ,36'h9_9999_9999},
    '{1'b0,1'b1,1'b1,3'b010,4'h0,1'b0,6'd4 ,36'h0}
  };
  localparam string TAGS [N] = '{
    "R3","R7","R4","R4","R2","R3","R5","R5","R5","R5","R6","R8","R9","R6","R8","R8",
    "R8","R8","R9","R4","R8","R8","R8","R8","R8","R7","R7","R7","R7","R5","R9","R9"
  };

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] model [1 << AW];
  int            pk [2];
  logic [AW-1:0] pa [2];
  logic [LN-1:0] pm [2];
  logic [DW-1:0] pd [2];
  string         pt [2];
  int            bKind;
  logic [AW-1:0] bBase;
  logic [1:0]    bCnt;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 2; i++) begin
      pk[i] = 0; pa[i] = '0; pm[i] = '0; pd[i] = '0; pt[i] = "R1";
    end
    bKind = 0; bBase = '0; bCnt = 2'd0;
  endtask

  task automatic cycle(input rowT r, input string tag);
    logic [DW-1:0] prevData;
    logic          prevValid;
    int            k;
    logic [AW-1:0] na;
    @(negedge clk);
    clkEnN = r.sus; ldN = r.ld; wrN = r.wr; {selN, selHi, selN2} = r.en;
    byteEnN = r.be; burstIlv = r.ilv; addr = r.a;
    wrData = r.sus ? r.d : pd[1];
    prevData = rdData; prevValid = rdValid;
    @(posedge clk); #1;
    if (r.sus) begin
      check(rdValid == prevValid, "R6 valid hold", DW'(rdValid), DW'(prevValid));
      check(rdData == prevData, "R6 data hold", rdData, prevData);
    end else begin
      if (!r.ld) begin
        k = (r.en == 3'b010) ? (r.wr ? 1 : 2) : 0;
        na = r.a; bBase = r.a; bCnt = 2'd0; bKind = k;
      end else begin
        bCnt = bCnt + 2'd1; k = bKind;
        na = {bBase[AW-1:2], r.ilv ? (bBase[1:0] ^ bCnt) : (bBase[1:0] + bCnt)};
      end
      if (pk[1] == 2) begin
        for (int i = 0; i < LN; i++)
          if (pm[1][i]) model[pa[1]][i*LW +: LW] = pd[1][i*LW +: LW];
        check(!rdValid, {pt[1], " R3 write slot"}, DW'(rdValid), '0);
      end else if (pk[1] == 1) begin
        check(rdValid, {pt[1], " R2 read valid"}, DW'(rdValid), DW'(1));
        check(rdData == model[pa[1]], {pt[1], " read data"}, rdData, model[pa[1]]);
      end else begin
        check(!rdValid, {pt[1], " R5 idle slot"}, DW'(rdValid), '0);
      end
      pk[1] = pk[0]; pa[1] = pa[0]; pm[1] = pm[0]; pd[1] = pd[0]; pt[1] = pt[0];
      pk[0] = k; pa[0] = na; pm[0] = ~r.be; pd[0] = r.d; pt[0] = tag;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; clkEnN = 1'b0; ldN = 1'b0; wrN = 1'b1;
    {selN, selHi, selN2} = 3'b110; byteEnN = '0; burstIlv = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!rdValid, "R1 valid in reset", DW'(rdValid), '0);
    check(rdData == '0, "R1 data in reset", rdData, '0);
    @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  rowT flushRow;
  rowT contRow;
  rowT preRow;

  initial begin
    flushRow = '{1'b0,1'b0,1'b1,3'b110,4'h0,1'b0,6'd0,36'h0};
    contRow  = '{1'b0,1'b1,1'b0,3'b010,4'h0,1'b0,6'd1,36'h5_5555_5555};
    doReset();
    // R9: continue edges straight after reset are deselects
    for (int i = 0; i < 4; i++) cycle(contRow, "R9");
    // R3: fill the array with back-to-back writes
    for (int a = 0; a < (1 << AW); a++) begin
      preRow = '{1'b0,1'b0,1'b0,3'b010,4'h0,1'b0,AW'(a),
                 DW'(36'h0_0F0F_0000) ^ DW'(a * 36'h1_0204_0811)};
      cycle(preRow, "R3");
    end
    for (int i = 0; i < N; i++) cycle(TBL[i], TAGS[i]);
    for (int i = 0; i < 2; i++) cycle(flushRow, "R5");
    // R1: mid-run reset clears the output
    doReset();
    check(!rdValid, "R1 after release", DW'(rdValid), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule